// File: doc/BRIEF.md
# Self-Routing Banyan Switch Fabric

This block is an 8x8 packet fabric built only from 2x2 switching elements laid out in three pipelined stages. Every input port presents a valid bit, a binary destination port number and a data word. No controller is involved: each element reads one bit of the destination number and steers the packet to its upper or lower output. After enough stages the packet sits on the output port that its destination number names.

Each stage ends in a register, so a packet that survives leaves the fabric a fixed number of cycles after it enters. Two packets can ask for the same output of one element. When that happens the element keeps the packet on its upper input and discards the other one. The discard is reported as a one-cycle pulse on a per-stage vector, in the bit that names the port the lost packet came from. Every delivered packet carries its entry port number as a label, so the receiving side knows where it came from.

The port count and data width are parameters. With the defaults there are 8 ports, 3 stages and 8-bit data.

Top module: `banyan_fabric`

## Requirements
- R1: A clock edge with rst_n low clears every out_valid bit and every drop_pulse bit from the next cycle on. Packets that were in flight at that moment are lost.
- R2: A packet that does not collide leaves on the output port equal to its destination number, with its data word unchanged.
- R3: Whenever out_valid[p] is 1, out_tag at port p equals p.
- R4: A surviving packet is presented on in_* before clock edge k and appears on the outputs after edge k+2, which is 3 cycles for the default 3 stages. No earlier edge shows it.
- R5: Whenever out_valid[p] is 1, out_src at port p gives the input port the packet entered on.
- R6: The wiring is as follows. Stage s decides on destination bit n-1-s, so stage 0 uses the most significant bit. A 0 selects the upper output and a 1 the lower output. After stage s, a packet that entered on port p with destination t occupies the internal line whose bits n-1 down to n-1-s come from t and whose remaining bits come from p. An element in stage s joins the two lines that differ only in bit n-1-s, and the line with that bit 0 is its upper side.
- R7: If two valid packets in one element ask for the same output, the packet on the upper input goes on and the other is dropped. The drop sets bit s*N+src of drop_pulse for exactly one cycle, where N is the port count and src is the lost packet's entry port. The pulse appears after clock edge k+s for a packet presented before edge k.
- R8: An input with in_valid low never collides with anything, never produces an out_valid and never produces a drop pulse, whatever its destination number and data.
- R9: A full load in which input p goes to destination p XOR k, for any constant k, is delivered completely with no drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | N | Per-port packet present |
| in_tag | input | N*PORT_BITS | Per-port destination number, port p in bits [p*PORT_BITS +: PORT_BITS] |
| in_data | input | N*DATA_W | Per-port data word, port p in bits [p*DATA_W +: DATA_W] |
| out_valid | output | N | Per-port packet delivered |
| out_tag | output | N*PORT_BITS | Destination number of the delivered packet |
| out_src | output | N*PORT_BITS | Entry port of the delivered packet |
| out_data | output | N*DATA_W | Data word of the delivered packet |
| drop_pulse | output | STAGES*N | Bit s*N+src pulses when stage s discards the packet from entry port src |

## Verification
The bench treats the whole fabric as visible state, because a wrong element decision or a miswired link always shows at the ports within three cycles. It shows up as a packet on the wrong output, a wrong entry label, altered data, or a drop pulse in the wrong stage or on the wrong source bit. Every wave of traffic is therefore drained before the next one is injected. The drop vectors are compared after edges 1, 2 and 3 against an arithmetic line-position model, and the outputs are compared after edge 3. This exposes a wrong winner, a swapped decision bit or a stage timing error in the same wave that caused it.

// File: rtl/banyan_pkg.sv
// Package: shared index arithmetic for the banyan fabric.
// Assumes the port count is a power of two.
package banyan_pkg;

    // Line index on the upper side of element `elem`, whose two lines
    // differ only in bit `bitpos`: a zero is inserted at that position.
    function automatic int upper_line(input int elem, input int bitpos);
        return ((elem >> bitpos) << (bitpos + 1)) | (elem & ((1 << bitpos) - 1));
    endfunction

    // Destination bit that a given stage decodes (stage 0 uses the MSB).
    function automatic int stage_sel_bit(input int stage, input int port_bits);
        return port_bits - 1 - stage;
    endfunction

endpackage

// File: rtl/banyan_elem.sv
// Module: one 2x2 switching element, purely combinational.
// It steers each valid packet by tag bit SEL: 0 goes to dn0 (upper),
// 1 goes to dn1 (lower). If both valid packets want the same side, the
// upper input wins and the lower input's packet is reported as dropped.
// Assumes SEL < TAG_W.
module banyan_elem #(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 8,
    parameter int SEL    = 2
) (
    input  logic              up_vld,
    input  logic [TAG_W-1:0]  up_tag,
    input  logic [TAG_W-1:0]  up_src,
    input  logic [DATA_W-1:0] up_data,
    input  logic              lo_vld,
    input  logic [TAG_W-1:0]  lo_tag,
    input  logic [TAG_W-1:0]  lo_src,
    input  logic [DATA_W-1:0] lo_data,
    output logic              dn0_vld,
    output logic [TAG_W-1:0]  dn0_tag,
    output logic [TAG_W-1:0]  dn0_src,
    output logic [DATA_W-1:0] dn0_data,
    output logic              dn1_vld,
    output logic [TAG_W-1:0]  dn1_tag,
    output logic [TAG_W-1:0]  dn1_src,
    output logic [DATA_W-1:0] dn1_data,
    output logic              drop_vld,
    output logic [TAG_W-1:0]  drop_src
);

    logic up_dir, lo_dir;
    logic take0_up, take0_lo, take1_up, take1_lo;

    // Decode the steering bit of each input.
    always_comb begin
        up_dir = up_tag[SEL];
        lo_dir = lo_tag[SEL];
    end

    // Grant each output side: the upper input has priority.
    always_comb begin
        take0_up = up_vld & ~up_dir;
        take1_up = up_vld &  up_dir;
        take0_lo = lo_vld & ~lo_dir & ~take0_up;
        take1_lo = lo_vld &  lo_dir & ~take1_up;
    end

    // Upper output mux.
    always_comb begin
        dn0_vld  = take0_up | take0_lo;
        dn0_tag  = take0_up ? up_tag  : lo_tag;
        dn0_src  = take0_up ? up_src  : lo_src;
        dn0_data = take0_up ? up_data : lo_data;
    end

    // Lower output mux.
    always_comb begin
        dn1_vld  = take1_up | take1_lo;
        dn1_tag  = take1_up ? up_tag  : lo_tag;
        dn1_src  = take1_up ? up_src  : lo_src;
        dn1_data = take1_up ? up_data : lo_data;
    end

    // Loss report: a valid lower packet that received no grant.
    always_comb begin
        drop_vld = lo_vld & ~(take0_lo | take1_lo);
        drop_src = lo_src;
    end

endmodule

// File: rtl/banyan_stage.sv
// Module: one registered fabric stage of N/2 elements.
// Element e joins the two lines that differ only in the stage's decode
// bit. The results and a one-hot-by-source drop vector are registered.
// Assumes a synchronous active-low reset and N = 2**PORT_BITS.
module banyan_stage
    import banyan_pkg::*;
#(
    parameter int PORT_BITS = 3,
    parameter int DATA_W    = 8,
    parameter int STAGE     = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [(1<<PORT_BITS)-1:0]           in_vld,
    input  logic [(1<<PORT_BITS)*PORT_BITS-1:0] in_tag,
    input  logic [(1<<PORT_BITS)*PORT_BITS-1:0] in_src,
    input  logic [(1<<PORT_BITS)*DATA_W-1:0]    in_data,
    output logic [(1<<PORT_BITS)-1:0]           out_vld,
    output logic [(1<<PORT_BITS)*PORT_BITS-1:0] out_tag,
    output logic [(1<<PORT_BITS)*PORT_BITS-1:0] out_src,
    output logic [(1<<PORT_BITS)*DATA_W-1:0]    out_data,
    output logic [(1<<PORT_BITS)-1:0]           drop_o
);

    localparam int N     = 1 << PORT_BITS;
    localparam int ELEMS = N / 2;
    localparam int SEL   = stage_sel_bit(STAGE, PORT_BITS);

    logic                 nx_vld  [N];
    logic [PORT_BITS-1:0] nx_tag  [N];
    logic [PORT_BITS-1:0] nx_src  [N];
    logic [DATA_W-1:0]    nx_data [N];
    logic                 e_drop  [ELEMS];
    logic [PORT_BITS-1:0] e_dsrc  [ELEMS];
    logic [N-1:0]         drop_nx;

    genvar e;
    generate
        for (e = 0; e < ELEMS; e++) begin : g_elem
            localparam int UP = upper_line(e, SEL);
            localparam int LO = UP + (1 << SEL);
            banyan_elem #(
                .TAG_W (PORT_BITS),
                .DATA_W(DATA_W),
                .SEL   (SEL)
            ) u_elem (
                .up_vld  (in_vld[UP]),
                .up_tag  (in_tag[UP*PORT_BITS +: PORT_BITS]),
                .up_src  (in_src[UP*PORT_BITS +: PORT_BITS]),
                .up_data (in_data[UP*DATA_W +: DATA_W]),
                .lo_vld  (in_vld[LO]),
                .lo_tag  (in_tag[LO*PORT_BITS +: PORT_BITS]),
                .lo_src  (in_src[LO*PORT_BITS +: PORT_BITS]),
                .lo_data (in_data[LO*DATA_W +: DATA_W]),
                .dn0_vld (nx_vld[UP]),
                .dn0_tag (nx_tag[UP]),
                .dn0_src (nx_src[UP]),
                .dn0_data(nx_data[UP]),
                .dn1_vld (nx_vld[LO]),
                .dn1_tag (nx_tag[LO]),
                .dn1_src (nx_src[LO]),
                .dn1_data(nx_data[LO]),
                .drop_vld(e_drop[e]),
                .drop_src(e_dsrc[e])
            );
        end
    endgenerate

    // Gather element losses into a vector indexed by entry port.
    always_comb begin
        drop_nx = '0;
        for (int k = 0; k < ELEMS; k++) begin
            if (e_drop[k]) drop_nx[e_dsrc[k]] = 1'b1;
        end
    end

    // Stage pipeline register for packets and drop reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= '0;
            out_tag  <= '0;
            out_src  <= '0;
            out_data <= '0;
            drop_o   <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                out_vld[k]                         <= nx_vld[k];
                out_tag[k*PORT_BITS +: PORT_BITS]  <= nx_tag[k];
                out_src[k*PORT_BITS +: PORT_BITS]  <= nx_src[k];
                out_data[k*DATA_W +: DATA_W]       <= nx_data[k];
            end
            drop_o <= drop_nx;
        end
    end

endmodule

// File: rtl/banyan_fabric.sv
// Module: top of the self-routing banyan fabric.
// It chains PORT_BITS registered stages and labels each packet with its
// entry port at the input. The output port index equals the packet's
// destination number, and latency is PORT_BITS cycles.
// Assumes a synchronous active-low reset.
module banyan_fabric #(
    parameter int PORT_BITS = 3,
    parameter int DATA_W    = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [(1<<PORT_BITS)-1:0]              in_valid,
    input  logic [(1<<PORT_BITS)*PORT_BITS-1:0]    in_tag,
    input  logic [(1<<PORT_BITS)*DATA_W-1:0]       in_data,
    output logic [(1<<PORT_BITS)-1:0]              out_valid,
    output logic [(1<<PORT_BITS)*PORT_BITS-1:0]    out_tag,
    output logic [(1<<PORT_BITS)*PORT_BITS-1:0]    out_src,
    output logic [(1<<PORT_BITS)*DATA_W-1:0]       out_data,
    output logic [PORT_BITS*(1<<PORT_BITS)-1:0]    drop_pulse
);

    localparam int N      = 1 << PORT_BITS;
    localparam int STAGES = PORT_BITS;

    logic [STAGES:0][N-1:0]           vld_bus;
    logic [STAGES:0][N*PORT_BITS-1:0] tag_bus;
    logic [STAGES:0][N*PORT_BITS-1:0] src_bus;
    logic [STAGES:0][N*DATA_W-1:0]    data_bus;

    // Fabric entry: the packet fields plus a constant entry-port label.
    assign vld_bus[0]  = in_valid;
    assign tag_bus[0]  = in_tag;
    assign data_bus[0] = in_data;

    genvar p, s;
    generate
        for (p = 0; p < N; p++) begin : g_label
            assign src_bus[0][p*PORT_BITS +: PORT_BITS] = PORT_BITS'(p);
        end

        for (s = 0; s < STAGES; s++) begin : g_stage
            banyan_stage #(
                .PORT_BITS(PORT_BITS),
                .DATA_W   (DATA_W),
                .STAGE    (s)
            ) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_vld  (vld_bus[s]),
                .in_tag  (tag_bus[s]),
                .in_src  (src_bus[s]),
                .in_data (data_bus[s]),
                .out_vld (vld_bus[s+1]),
                .out_tag (tag_bus[s+1]),
                .out_src (src_bus[s+1]),
                .out_data(data_bus[s+1]),
                .drop_o  (drop_pulse[s*N +: N])
            );
        end
    endgenerate

    // Fabric exit: the last stage drives the output ports directly.
    assign out_valid = vld_bus[STAGES];
    assign out_tag   = tag_bus[STAGES];
    assign out_src   = src_bus[STAGES];
    assign out_data  = data_bus[STAGES];

endmodule

// File: rtl/banyan_fabric_chk.sv
// Checker: port-level properties of banyan_fabric, bound to the top.
// It keeps its own delayed copies of the inputs so that outputs and drops
// can be related to what entered. Assumes the same reset as the DUT.
module banyan_fabric_chk #(
    parameter int PORT_BITS = 3,
    parameter int DATA_W    = 8
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [(1<<PORT_BITS)-1:0]           in_valid,
    input logic [(1<<PORT_BITS)*DATA_W-1:0]    in_data,
    input logic [(1<<PORT_BITS)-1:0]           out_valid,
    input logic [(1<<PORT_BITS)*PORT_BITS-1:0] out_tag,
    input logic [(1<<PORT_BITS)*PORT_BITS-1:0] out_src,
    input logic [(1<<PORT_BITS)*DATA_W-1:0]    out_data,
    input logic [PORT_BITS*(1<<PORT_BITS)-1:0] drop_pulse
);

    localparam int N      = 1 << PORT_BITS;
    localparam int STAGES = PORT_BITS;

    logic [N-1:0]        vld_d  [STAGES];
    logic [N*DATA_W-1:0] data_d [STAGES];

    // Input history, one entry per stage of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                vld_d[k]  <= '0;
                data_d[k] <= '0;
            end
        end else begin
            vld_d[0]  <= in_valid;
            data_d[0] <= in_data;
            for (int k = 1; k < STAGES; k++) begin
                vld_d[k]  <= vld_d[k-1];
                data_d[k] <= data_d[k-1];
            end
        end
    end

    genvar p, s;
    generate
        for (p = 0; p < N; p++) begin : g_port
            // R3
            out_tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[p] |-> out_tag[p*PORT_BITS +: PORT_BITS] == PORT_BITS'(p));
            // R4
            exact_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[p] |-> vld_d[STAGES-1][out_src[p*PORT_BITS +: PORT_BITS]]);
            // R2
            data_intact_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[p] |-> out_data[p*DATA_W +: DATA_W] ==
                    data_d[STAGES-1][out_src[p*PORT_BITS +: PORT_BITS]*DATA_W +: DATA_W]);
        end

        for (s = 0; s < STAGES; s++) begin : g_stg
            // R7
            drop_per_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(drop_pulse[s*N +: N]) <= N/2);
            for (p = 0; p < N; p++) begin : g_src
                // R8
                drop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    drop_pulse[s*N + p] |-> vld_d[s][p]);
            end
        end
    endgenerate

endmodule

bind banyan_fabric banyan_fabric_chk #(
    .PORT_BITS(PORT_BITS),
    .DATA_W   (DATA_W)
) u_fabric_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_src   (out_src),
    .out_data  (out_data),
    .drop_pulse(drop_pulse)
);

// File: tb/banyan_fabric_tb.sv
// Bench: drives one wave of traffic at a time, drains it and compares each
// stage's drops and the outputs against an arithmetic line-position model.
module banyan_fabric_tb;

    localparam int PB = 3;
    localparam int N  = 8;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      in_valid = '0;
    logic [N*PB-1:0]   in_tag = '0;
    logic [N*DW-1:0]   in_data = '0;
    logic [N-1:0]      out_valid;
    logic [N*PB-1:0]   out_tag;
    logic [N*PB-1:0]   out_src;
    logic [N*DW-1:0]   out_data;
    logic [PB*N-1:0]   drop_pulse;

    int total = 0;
    int fails = 0;
    int wave_id = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    banyan_fabric #(.PORT_BITS(PB), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_data(in_data), .out_valid(out_valid), .out_tag(out_tag),
        .out_src(out_src), .out_data(out_data), .drop_pulse(drop_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pay(input int w, input int p);
        return DW'(w * 37 + p * 11 + 5);
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    // Inject one wave, then check drops after edges 1..3 and outputs after edge 3.
    task automatic run_wave(input logic [N-1:0] v, input logic [N*PB-1:0] tg,
                            input string req);
        logic [N-1:0] edrop [PB];
        logic [N-1:0] alive;
        logic [N-1:0] evld;
        int line [N];
        int nl [N];
        int esrc [N];
        int bad;
        alive = v;
        evld = '0;
        for (int p = 0; p < N; p++) begin line[p] = p; esrc[p] = 0; end
        for (int s = 0; s < PB; s++) begin
            int b = PB - 1 - s;
            edrop[s] = '0;
            for (int p = 0; p < N; p++)
                nl[p] = (line[p] & ~(1 << b)) | (int'(tg[p*PB + b]) << b);
            for (int p = 0; p < N; p++)
                for (int q = 0; q < N; q++)
                    if (p != q && alive[p] && alive[q] && nl[p] == nl[q] &&
                        ((line[p] >> b) & 1) == 1)
                        edrop[s][p] = 1'b1;
            alive = alive & ~edrop[s];
            for (int p = 0; p < N; p++) line[p] = nl[p];
        end
        for (int p = 0; p < N; p++)
            if (alive[p]) begin evld[line[p]] = 1'b1; esrc[line[p]] = p; end

        @(negedge clk);
        in_valid = v;
        in_tag = tg;
        for (int p = 0; p < N; p++) in_data[p*DW +: DW] = pay(wave_id, p);
        for (int s = 0; s < PB; s++) begin
            @(negedge clk);
            in_valid = '0;
            in_tag = ~tg;
            check(drop_pulse[s*N +: N] == edrop[s], req, $sformatf("drops stage %0d", s),
                  drop_pulse[s*N +: N], edrop[s]);
            if (s < PB - 1)
                check(out_valid == '0, "R4", "early output", out_valid, 0);
        end
        check(out_valid == evld, req, "valid mask", out_valid, evld);
        bad = 0;
        for (int o = 0; o < N; o++)
            if (evld[o] && out_valid[o]) begin
                if (out_src[o*PB +: PB] != PB'(esrc[o])) bad++;          // R5
                if (out_data[o*DW +: DW] != pay(wave_id, esrc[o])) bad++; // R2
                if (out_tag[o*PB +: PB] != PB'(o)) bad++;               // R3
            end
        check(bad == 0, req, "label/data/tag mismatches", bad, 0);
        wave_id++;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [N*PB-1:0] tg;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
        check(drop_pulse == '0, "R1", "drop_pulse after reset", drop_pulse, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R5: single packet from every port to every destination
        for (int p = 0; p < N; p++)
            for (int t = 0; t < N; t++) begin
                rng = next_rng(rng);
                tg = rng[N*PB-1:0];
                tg[p*PB +: PB] = PB'(t);
                run_wave(N'(1) << p, tg, "R2");
            end

        // R9: XOR permutations, full load, no drops
        for (int k = 0; k < N; k++) begin
            for (int p = 0; p < N; p++) tg[p*PB +: PB] = PB'(p ^ k);
            run_wave('1, tg, "R9");
        end

        // R7: hot spot, every port to one destination
        for (int t = 0; t < N; t++) begin
            for (int p = 0; p < N; p++) tg[p*PB +: PB] = PB'(t);
            run_wave('1, tg, "R7");
        end

        // R8: invalid inputs with conflicting tags
        for (int p = 0; p < N; p++) tg[p*PB +: PB] = '0;
        run_wave('0, tg, "R8");
        run_wave(8'b0000_0001, tg, "R8");
        run_wave(8'b1000_0000, tg, "R8");
        run_wave(8'b0001_0000, tg, "R8");

        // R6: pseudo-random loads against the line model
        for (int w = 0; w < 150; w++) begin
            rng = next_rng(rng);
            tg = rng[N*PB-1:0];
            rng = next_rng(rng);
            run_wave(rng[N-1:0], tg, "R6");
        end

        // R1: reset while a full wave is in flight
        @(negedge clk);
        in_valid = '1;
        for (int p = 0; p < N; p++) tg[p*PB +: PB] = '0;
        in_tag = tg;
        @(negedge clk);
        in_valid = '0;
        rst_n = 1'b0;
        @(negedge clk);
        check(drop_pulse == '0, "R1", "drops after mid-run reset", drop_pulse, 0);
        check(out_valid == '0, "R1", "outputs after mid-run reset", out_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == '0, "R1", "flushed wave stays lost", out_valid, 0);
        check(drop_pulse == '0, "R1", "no late drops", drop_pulse, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule